// File: doc/BRIEF.md
# Single-Operand and Literal File-Register Datapath

This block is the execute slice for a small group of instructions in an 8-bit accumulator core. Each instruction reads one entry from a 32-entry register file, or uses the working register W together with an 8-bit literal. It computes one 8-bit result and writes it to W or back to the file entry.

Five operations are supported:

- decrement;
- increment;
- decrement with a skip request on a zero result;
- increment with a skip request on a zero result;
- OR of W with a literal.

The zero flag is updated only by the plain arithmetic operations and by the OR. The skip request tells the surrounding sequencer to discard the instruction it has already fetched.

The caller presents an opcode, a file address, a destination bit and a literal, and qualifies them with `op_valid`. All state changes on the rising clock edge where `op_valid` is high. A second, independent read port gives the core combinational access to any file entry.

Top module: `fileop_alu`

## Requirements
- R1: While `rst_n` is low on a clock edge, W, the zero flag, the skip request and all 32 file entries are cleared to zero.
- R2: Opcode 3'd1 (decrement) and opcode 3'd3 (decrement-skip) compute file[f] minus 1 modulo 256, so 0x00 gives 0xFF.
- R3: Opcode 3'd2 (increment) and opcode 3'd4 (increment-skip) compute file[f] plus 1 modulo 256, so 0xFF gives 0x00.
- R4: For opcodes 1 to 4, destination bit 0 writes the result to W and leaves the file unchanged. Destination bit 1 writes the result to file[f] and leaves W unchanged.
- R5: Opcodes 1 and 2 set the zero flag when the 8-bit result is zero and clear it otherwise.
- R6: Opcodes 3 and 4 leave the zero flag unchanged.
- R7: `skip_req` is high for exactly the cycle after an accepted opcode 3 or 4 whose result is zero, and low after every other cycle.
- R8: Opcode 3'd5 writes W OR literal into W and sets the zero flag from that result. It ignores the destination bit and does not change the file.
- R9: A cycle with `op_valid` low, or with opcode 3'd0 (or any of the codes 6 and 7), changes no state and produces no skip request.
- R10: W, the zero flag, the file entry and `skip_req` all show their new values right after the clock edge that accepts the instruction. `file_rd_data` follows `file_rd_addr` combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | Qualifies the instruction fields this cycle |
| op_code | input | 3 | Operation select (see R2 to R9) |
| op_addr | input | 5 | File register address f |
| op_dest | input | 1 | 0: result to W, 1: result to file[f] |
| op_lit | input | 8 | Literal for the OR operation |
| file_rd_addr | input | 5 | Address of the independent file read port |
| file_rd_data | output | 8 | Contents of the addressed file entry |
| w_q | output | 8 | Working register W |
| z_q | output | 1 | Zero flag |
| skip_req | output | 1 | Discard-next-instruction request |

## Verification
Every registered result — W, the zero flag, the written file entry and the skip pulse — is due one clock edge after the instruction is accepted. The only exception is the read port, which is combinational.

Each scenario drives its fields on a falling edge and lets one rising edge pass. It withdraws `op_valid` on the next falling edge and compares all outputs there. In that half cycle `skip_req` is still showing the pulse for this instruction, before the next edge clears it. File contents are read back through the read port a moment after the address is applied, with no clock edge in between.

// File: rtl/fileop_pkg.sv
// Package: shared opcode type for the single-operand / literal datapath.
// Assumes opcode values are fixed by the surrounding decoder as listed here.
package fileop_pkg;
    typedef enum logic [2:0] {
        OPC_NOP     = 3'd0,
        OPC_DEC     = 3'd1,
        OPC_INC     = 3'd2,
        OPC_DEC_SKP = 3'd3,
        OPC_INC_SKP = 3'd4,
        OPC_OR_LIT  = 3'd5
    } opc_e;
endpackage

// File: rtl/fop_regfile.sv
// Module: register file with one write port and two asynchronous read ports.
// Port A feeds the operand path; port B is the core's general read access.
// Assumes addresses at or above DEPTH read as zero and are never written.
module fop_regfile #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 32,
    parameter int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] ra_addr,
    output logic [DATA_W-1:0] ra_data,
    input  logic [ADDR_W-1:0] rb_addr,
    output logic [DATA_W-1:0] rb_data
);
    logic [DATA_W-1:0] mem [DEPTH];

    for (genvar e = 0; e < DEPTH; e++) begin : g_entry
        // Purpose: hold one entry, cleared on reset, loaded when addressed.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mem[e] <= '0;
            end else if (wr_en && (wr_addr == ADDR_W'(e))) begin
                mem[e] <= wr_data;
            end
        end
    end

    // Purpose: operand read, zero outside the populated range.
    always_comb begin
        ra_data = '0;
        if (int'(ra_addr) < DEPTH) ra_data = mem[ra_addr];
    end

    // Purpose: general read port, zero outside the populated range.
    always_comb begin
        rb_data = '0;
        if (int'(rb_addr) < DEPTH) rb_data = mem[rb_addr];
    end
endmodule

// File: rtl/fop_alu.sv
// Module: combinational result and routing logic for the five operations.
// Assumes the opcode is already decoded into the package enum; undefined
// codes behave as no-operation (no destination, no flag, no skip).
module fop_alu
    import fileop_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  opc_e              code,
    input  logic              dest,
    input  logic [DATA_W-1:0] operand,
    input  logic [DATA_W-1:0] wval,
    input  logic [DATA_W-1:0] lit,
    output logic [DATA_W-1:0] result,
    output logic              res_zero,
    output logic              to_w,
    output logic              to_file,
    output logic              z_upd,
    output logic              skip_op
);
    logic is_step;

    // Purpose: result value, modulo 2**DATA_W for the step operations.
    always_comb begin
        unique case (code)
            OPC_DEC, OPC_DEC_SKP: result = operand - DATA_W'(1);
            OPC_INC, OPC_INC_SKP: result = operand + DATA_W'(1);
            OPC_OR_LIT:           result = wval | lit;
            default:              result = operand;
        endcase
    end

    // Purpose: destination, flag-update and skip classification.
    always_comb begin
        is_step  = (code == OPC_DEC) || (code == OPC_INC) ||
                   (code == OPC_DEC_SKP) || (code == OPC_INC_SKP);
        skip_op  = (code == OPC_DEC_SKP) || (code == OPC_INC_SKP);
        z_upd    = (code == OPC_DEC) || (code == OPC_INC) || (code == OPC_OR_LIT);
        to_file  = is_step && dest;
        to_w     = (code == OPC_OR_LIT) || (is_step && !dest);
        res_zero = (result == '0);
    end
endmodule

// File: rtl/fop_wstate.sv
// Module: working register, zero flag and skip-request registers.
// Assumes the routing strobes are already qualified by instruction validity.
module fop_wstate #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              w_load,
    input  logic              z_load,
    input  logic              skip_set,
    input  logic [DATA_W-1:0] result,
    input  logic              res_zero,
    output logic [DATA_W-1:0] w_q,
    output logic              z_q,
    output logic              skip_q
);
    // Purpose: W register, loaded only when W is the destination.
    always_ff @(posedge clk) begin
        if (!rst_n)      w_q <= '0;
        else if (w_load) w_q <= result;
    end

    // Purpose: zero flag, updated only by flag-affecting operations.
    always_ff @(posedge clk) begin
        if (!rst_n)      z_q <= 1'b0;
        else if (z_load) z_q <= res_zero;
    end

    // Purpose: one-cycle skip pulse after a zero result of a skip operation.
    always_ff @(posedge clk) begin
        if (!rst_n) skip_q <= 1'b0;
        else        skip_q <= skip_set;
    end
endmodule

// File: rtl/fileop_alu.sv
// Module: top of the single-operand / literal datapath. It joins the
// register file, the result logic and the W/flag state. Assumes one
// instruction per cycle, qualified by op_valid, with no stalls.
module fileop_alu
    import fileop_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 32,
    parameter int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [2:0]        op_code,
    input  logic [ADDR_W-1:0] op_addr,
    input  logic              op_dest,
    input  logic [DATA_W-1:0] op_lit,
    input  logic [ADDR_W-1:0] file_rd_addr,
    output logic [DATA_W-1:0] file_rd_data,
    output logic [DATA_W-1:0] w_q,
    output logic              z_q,
    output logic              skip_req
);
    opc_e              code;
    logic [DATA_W-1:0] operand;
    logic [DATA_W-1:0] result;
    logic              res_zero, to_w, to_file, z_upd, skip_op;

    assign code = opc_e'(op_code);

    fop_regfile #(.DATA_W(DATA_W), .DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (op_valid && to_file),
        .wr_addr (op_addr),
        .wr_data (result),
        .ra_addr (op_addr),
        .ra_data (operand),
        .rb_addr (file_rd_addr),
        .rb_data (file_rd_data)
    );

    fop_alu #(.DATA_W(DATA_W)) u_alu (
        .code     (code),
        .dest     (op_dest),
        .operand  (operand),
        .wval     (w_q),
        .lit      (op_lit),
        .result   (result),
        .res_zero (res_zero),
        .to_w     (to_w),
        .to_file  (to_file),
        .z_upd    (z_upd),
        .skip_op  (skip_op)
    );

    fop_wstate #(.DATA_W(DATA_W)) u_ws (
        .clk      (clk),
        .rst_n    (rst_n),
        .w_load   (op_valid && to_w),
        .z_load   (op_valid && z_upd),
        .skip_set (op_valid && skip_op && res_zero),
        .result   (result),
        .res_zero (res_zero),
        .w_q      (w_q),
        .z_q      (z_q),
        .skip_q   (skip_req)
    );
endmodule

// File: rtl/fileop_alu_chk.sv
// Module: property checker bound to fileop_alu. It observes ports only.
// Assumes reset is held from time zero until the first clock edges.
module fileop_alu_chk #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              op_valid,
    input logic [2:0]        op_code,
    input logic              op_dest,
    input logic [DATA_W-1:0] op_lit,
    input logic [ADDR_W-1:0] op_addr,
    input logic [DATA_W-1:0] w_q,
    input logic              z_q,
    input logic              skip_req
);
    logic skip_in, step_in, zop_in;
    assign skip_in = op_valid && (op_code == 3'd3 || op_code == 3'd4);
    assign step_in = op_valid && (op_code >= 3'd1 && op_code <= 3'd4);
    assign zop_in  = op_valid && (op_code == 3'd1 || op_code == 3'd2);

    // R7: a skip pulse only follows an accepted skip operation
    p_skip_source_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(skip_req) |-> $past(skip_in));

    // R6: skip operations keep the zero flag
    p_z_kept_r6: assert property (@(posedge clk) disable iff (!rst_n)
        skip_in |=> $stable(z_q));

    // R9: idle cycles change nothing and never skip
    p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> ($stable(w_q) && $stable(z_q) && !skip_req));

    // R8: OR literal result lands in W
    p_or_into_w_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == 3'd5) |=> (w_q == ($past(w_q) | $past(op_lit))));

    // R4: file destination leaves W unchanged
    p_file_dest_w_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (step_in && op_dest) |=> $stable(w_q));

    // R5: plain step into W sets Z exactly when W becomes zero
    p_z_from_w_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (zop_in && !op_dest) |=> (z_q == (w_q == '0)));

    // R10: address input is only meaningful with known value when valid
    p_addr_known_r10: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |-> !$isunknown(op_addr));
endmodule

bind fileop_alu fileop_alu_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .op_valid (op_valid),
    .op_code  (op_code),
    .op_dest  (op_dest),
    .op_lit   (op_lit),
    .op_addr  (op_addr),
    .w_q      (w_q),
    .z_q      (z_q),
    .skip_req (skip_req)
);

// File: tb/test_fileop_alu.sv
module test_fileop_alu;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       op_valid = 1'b0;
    logic [2:0] op_code = 3'd0;
    logic [4:0] op_addr = 5'd0;
    logic       op_dest = 1'b0;
    logic [7:0] op_lit = 8'd0;
    logic [4:0] file_rd_addr = 5'd0;
    logic [7:0] file_rd_data, w_q;
    logic       z_q, skip_req;

    int checks = 0, errors = 0;
    bit done = 0;
    logic [7:0] mw;
    logic       mz;
    logic [7:0] mf [32];

    always #10 clk = ~clk;

    fileop_alu i_fileop_alu (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .op_addr(op_addr), .op_dest(op_dest), .op_lit(op_lit),
        .file_rd_addr(file_rd_addr), .file_rd_data(file_rd_data),
        .w_q(w_q), .z_q(z_q), .skip_req(skip_req)
    );

    task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic chk_file(input string req);
        for (int a = 0; a < 32; a++) begin
            file_rd_addr = 5'(a);
            #1;
            chk(req, $sformatf("file[%0d]", a), file_rd_data, mf[a]);
        end
    endtask

    // Issue one instruction, update the model from the requirements, compare.
    task automatic issue(input logic v, input logic [2:0] c, input int a,
                         input logic d, input logic [7:0] k, input string req);
        logic [7:0] r;
        logic       sk;
        @(negedge clk);
        op_valid = v; op_code = c; op_addr = 5'(a); op_dest = d; op_lit = k;
        @(negedge clk);
        op_valid = 1'b0;
        sk = 1'b0;
        if (v) begin
            case (c)
                3'd1, 3'd3: r = mf[a] - 8'd1;
                3'd2, 3'd4: r = mf[a] + 8'd1;
                3'd5:       r = mw | k;
                default:    r = 8'hxx;
            endcase
            if (c >= 3'd1 && c <= 3'd4) begin
                if (d) mf[a] = r; else mw = r;
                if (c <= 3'd2) mz = (r == 8'd0);
                else sk = (r == 8'd0);
            end else if (c == 3'd5) begin
                mw = r; mz = (r == 8'd0);
            end
        end
        chk(req, "w_q", w_q, mw);
        chk(req, "z_q", {7'd0, z_q}, {7'd0, mz});
        chk(req, "skip_req", {7'd0, skip_req}, {7'd0, sk});
        file_rd_addr = 5'(a);
        #1;
        chk(req, "file[f]", file_rd_data, mf[a]);
    endtask

    task automatic t_reset();
        // R1: reset clears everything
        mw = 8'd0; mz = 1'b0;
        for (int a = 0; a < 32; a++) mf[a] = 8'd0;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk("R1", "w_q", w_q, 8'd0);
        chk("R1", "z_q", {7'd0, z_q}, 8'd0);
        chk("R1", "skip_req", {7'd0, skip_req}, 8'd0);
        chk_file("R1");
    endtask

    task automatic t_dec_inc();
        issue(1, 3'd1, 3, 1, 0, "R2");     // 00 -> FF wraps, Z clear
        issue(1, 3'd2, 3, 1, 0, "R3");     // FF -> 00 wraps, Z set (R5)
        issue(1, 3'd2, 3, 1, 0, "R5");     // 00 -> 01, Z clear
        issue(1, 3'd1, 3, 1, 0, "R5");     // 01 -> 00, Z set
        issue(1, 3'd2, 9, 1, 0, "R10");
    endtask

    task automatic t_dest();
        issue(1, 3'd2, 9, 0, 0, "R4");     // W = 02, file[9] stays 01
        issue(1, 3'd1, 9, 0, 0, "R4");     // W = 00, Z set
        chk_file("R4");
    endtask

    task automatic t_skip();
        issue(1, 3'd3, 5, 1, 0, "R7");     // 00 -> FF, no skip
        issue(1, 3'd4, 5, 1, 0, "R7");     // FF -> 00, skip
        issue(1, 3'd2, 7, 1, 0, "R6");     // file[7]=01, Z clear
        issue(1, 3'd3, 7, 1, 0, "R6");     // -> 00, skip, Z stays clear
        issue(1, 3'd3, 6, 0, 0, "R7");     // W = FF, no skip
        issue(1, 3'd4, 6, 0, 0, "R7");     // W = 01, no skip
        chk_file("R7");
    endtask

    task automatic t_or();
        issue(1, 3'd4, 5, 0, 0, "R8");     // W = 01
        issue(1, 3'd5, 0, 1, 8'h5A, "R8"); // W = 5B, dest ignored
        issue(1, 3'd1, 3, 0, 0, "R8");     // W = FF
        issue(1, 3'd2, 5, 0, 0, "R8");     // W = 01 prep
        issue(1, 3'd1, 20, 1, 0, "R8");    // file[20]=FF
        issue(1, 3'd2, 20, 0, 0, "R8");    // W = 00, Z set
        issue(1, 3'd5, 20, 1, 8'h00, "R8");// W = 00, Z set
        issue(1, 3'd5, 20, 0, 8'h80, "R8");// W = 80, Z clear
        chk_file("R8");
    endtask

    task automatic t_idle();
        issue(0, 3'd2, 4, 1, 8'hFF, "R9");
        issue(0, 3'd5, 4, 0, 8'h0F, "R9");
        issue(1, 3'd0, 4, 1, 8'hFF, "R9");
        issue(1, 3'd6, 4, 0, 8'hFF, "R9");
        issue(1, 3'd7, 4, 1, 8'hFF, "R9");
        chk_file("R9");
    endtask

    initial begin
        t_reset();
        t_dec_inc();
        t_dest();
        t_skip();
        t_or();
        t_idle();
        t_reset();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule